// File: doc/BRIEF.md
# Channel-Status Flag Extractor for a Digital Audio Receiver

This block sits behind a biphase-mark audio decoder and turns the channel-status bit stream into five control flags for a host processor. The decoder supplies one channel-status bit with each subframe strobe. It also marks the first frame of each 192-frame block and reports whether it is locked to the incoming stream. The extractor takes the bit from the left subframe of every frame. It counts frames from the block marker and keeps only the few bit positions it decodes. When a complete, aligned block has arrived under lock, it refreshes its flags.

The flags are the 44.1 kHz and 48 kHz rate indicators, a lock indicator, the pre-emphasis indicator and the non-PCM indicator. They appear as individual pins and are also packed into a read-only status word. The bits are always read with the consumer-format meaning. The professional, copy and data-mode bits do not affect decoding. The block only reports non-PCM content; it never mutes or gates audio, and any such action belongs to an outside controller.

The subframe input is a valid-only stream. The block accepts every strobe in the cycle it is presented and never applies back-pressure, so no ready signal exists. An upstream source may present strobes at any spacing, and the strobes may be back to back.

Top module: `spdif_cs_flags`

## Requirements
- R1: After reset all five flags and the whole status word are zero.
- R2: A bit is taken only in a cycle with `sf_valid` high and `sf_left` high. Right-subframe strobes have no effect on the flags.
- R3: A left strobe with `blk_start` high is bit 0 of a new block. After 191 more left strobes without `blk_start`, the flags take their new values in the cycle after the strobe of bit 191, and not earlier. A `blk_start` that arrives before a block completes restarts the count, and the interrupted block updates nothing.
- R4: After a block completes, left strobes without `blk_start` are ignored until the next `blk_start`, even if 192 of them arrive.
- R5: `flag_non_pcm` equals channel-status bit 1 of the last completed block.
- R6: `flag_pre_emph` is 1 when bit 3 = 1, bit 4 = 0 and bit 5 = 0 (bits 5..3 read as 001). It is 0 for every other combination.
- R7: `flag_fs_44k` is 1 when bits 24, 25, 26 and 27 are all 0.
- R8: `flag_fs_48k` is 1 when bit 25 = 1 and bits 24, 26 and 27 are 0 (bits 27..24 = 0010). The 32 kHz code (bits 27..24 = 0011) and every other code leave both rate flags at 0.
- R9: `flag_lock` becomes 1 at the end of a completed block. When the `lock` input is low at a clock edge, all five flags are 0 after that edge. A block that lock loss interrupts updates nothing, even after lock returns.
- R10: Between block completions, and while `lock` is high, the flags keep their values.
- R11: Bits 0 (professional), 2 (copy) and every bit other than 1, 3-5 and 24-27 have no effect on the flags.
- R12: `status_word` bit 0 = 44.1 kHz, bit 1 = 48 kHz, bit 2 = lock, bit 3 = pre-emphasis and bit 4 = non-PCM. All higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sf_valid | input | 1 | Subframe strobe, one cycle per subframe |
| sf_left | input | 1 | High when the strobed subframe is the left one |
| blk_start | input | 1 | High with the left strobe of block frame 0 |
| cs_bit | input | 1 | Channel-status bit of the strobed subframe |
| lock | input | 1 | Decoder lock indication |
| flag_fs_44k | output | 1 | Last block carried the 44.1 kHz code |
| flag_fs_48k | output | 1 | Last block carried the 48 kHz code |
| flag_lock | output | 1 | A full block was decoded under uninterrupted lock |
| flag_pre_emph | output | 1 | Pre-emphasis indicated |
| flag_non_pcm | output | 1 | Non-PCM content indicated |
| status_word | output | STATUS_W (8) | Packed read-only status |

## Verification
A wrong frame count or a wrong alignment state shows at the ports as flags that change one block too early, change at the wrong strobe, or never change. The bench samples the output one cycle before and one cycle after the strobe of bit 191, so an off-by-one position shows up at once. A bit stored at the wrong position gives wrong rate or emphasis flags at the next block completion, and the random blocks spread values over every decoded position. Stale alignment after lock loss or after a missing block marker shows as an unwanted update within one block time.

// File: rtl/spdif_cs_pkg.sv
`timescale 1ns/1ps
package spdif_cs_pkg;

  // Flag vector, LSB first: fs_44k, fs_48k, locked, pre_emph, non_pcm
  typedef struct packed {
    logic non_pcm;
    logic pre_emph;
    logic locked;
    logic fs_48k;
    logic fs_44k;
  } cs_flags_t;

  localparam int unsigned FLAG_W  = 5;
  // Retained channel-status positions:
  // field 0 = bit 1, fields 1..3 = bits 3..5, fields 4..7 = bits 24..27
  localparam int unsigned FIELD_W = 8;

  localparam logic [2:0] EMPH_CODE = 3'b001;   // {b5,b4,b3}
  localparam logic [3:0] RATE_44K  = 4'b0000;  // {b27,b26,b25,b24}
  localparam logic [3:0] RATE_48K  = 4'b0010;

  function automatic int unsigned cs_field_pos(input int unsigned k);
    if (k == 0)      return 1;
    else if (k < 4)  return k + 2;
    else             return k + 20;
  endfunction

endpackage

// File: rtl/cs_frame_tracker.sv
`timescale 1ns/1ps
module cs_frame_tracker #(
  parameter int unsigned FRAMES = 192,
  parameter int unsigned IDX_W  = $clog2(FRAMES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sf_valid,
  input  logic             sf_left,
  input  logic             blk_start,
  input  logic             lock,
  output logic             bit_we,
  output logic [IDX_W-1:0] bit_pos,
  output logic             blk_done
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAMES - 1);
  localparam logic [IDX_W-1:0] ONE  = IDX_W'(1);

  logic             aligned_q;
  logic [IDX_W-1:0] next_q;
  logic             accept;

  assign accept   = sf_valid & sf_left & lock;
  assign bit_we   = accept & (blk_start | aligned_q);
  assign bit_pos  = blk_start ? '0 : next_q;
  assign blk_done = accept & ~blk_start & aligned_q & (next_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aligned_q <= 1'b0;
      next_q    <= '0;
    end else if (!lock) begin
      aligned_q <= 1'b0;
      next_q    <= '0;
    end else if (accept) begin
      if (blk_start) begin
        aligned_q <= 1'b1;
        next_q    <= ONE;
      end else if (aligned_q) begin
        if (next_q == LAST) begin
          aligned_q <= 1'b0;
          next_q    <= '0;
        end else begin
          next_q <= next_q + ONE;
        end
      end
    end
  end

  // R3: a block marker restarts the count at position 1
  a_r3_start_realigns: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && blk_start) |=> (aligned_q && next_q == ONE));

  // R3: frame position never passes the block length
  a_r3_pos_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    next_q <= LAST);

  // R4: after a completed block the tracker waits for a marker
  a_r4_done_drops_align: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> !aligned_q);

endmodule

// File: rtl/cs_field_store.sv
`timescale 1ns/1ps
module cs_field_store
  import spdif_cs_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_we,
  input  logic [IDX_W-1:0]   bit_pos,
  input  logic               cs_bit,
  output logic [FIELD_W-1:0] fields_q
);

  for (genvar g = 0; g < FIELD_W; g++) begin : g_field
    localparam logic [IDX_W-1:0] POS = IDX_W'(cs_field_pos(g));
    always_ff @(posedge clk) begin
      if (!rst_n)
        fields_q[g] <= 1'b0;
      else if (bit_we && bit_pos == POS)
        fields_q[g] <= cs_bit;
    end
  end

endmodule

// File: rtl/cs_flag_decode.sv
`timescale 1ns/1ps
module cs_flag_decode
  import spdif_cs_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lock,
  input  logic               blk_done,
  input  logic [FIELD_W-1:0] fields,
  output cs_flags_t          flags_q
);

  cs_flags_t dec;

  always_comb begin
    dec          = '0;
    dec.non_pcm  = fields[0];
    dec.pre_emph = (fields[3:1] == EMPH_CODE);
    dec.fs_44k   = (fields[7:4] == RATE_44K);
    dec.fs_48k   = (fields[7:4] == RATE_48K);
    dec.locked   = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !lock)
      flags_q <= '0;
    else if (blk_done)
      flags_q <= dec;
  end

  // R9: loss of lock clears every flag
  a_r9_clear_on_unlock: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> (flags_q == '0));

  // R10: flags hold between completed blocks
  a_r10_hold_between_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !blk_done) |=> $stable(flags_q));

  // R9: lock flag only rises after a completed block
  a_r9_lock_after_block: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q.locked) |-> $past(blk_done));

endmodule

// File: rtl/spdif_cs_flags.sv
`timescale 1ns/1ps
module spdif_cs_flags
  import spdif_cs_pkg::*;
#(
  parameter int unsigned FRAMES   = 192,
  parameter int unsigned STATUS_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sf_valid,
  input  logic                sf_left,
  input  logic                blk_start,
  input  logic                cs_bit,
  input  logic                lock,
  output logic                flag_fs_44k,
  output logic                flag_fs_48k,
  output logic                flag_lock,
  output logic                flag_pre_emph,
  output logic                flag_non_pcm,
  output logic [STATUS_W-1:0] status_word
);

  localparam int unsigned IDX_W = $clog2(FRAMES);

  logic               bit_we;
  logic [IDX_W-1:0]   bit_pos;
  logic               blk_done;
  logic [FIELD_W-1:0] fields;
  cs_flags_t          flags;

  cs_frame_tracker #(.FRAMES(FRAMES), .IDX_W(IDX_W)) u_tracker (
    .clk       (clk),
    .rst_n     (rst_n),
    .sf_valid  (sf_valid),
    .sf_left   (sf_left),
    .blk_start (blk_start),
    .lock      (lock),
    .bit_we    (bit_we),
    .bit_pos   (bit_pos),
    .blk_done  (blk_done)
  );

  cs_field_store #(.IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_we   (bit_we),
    .bit_pos  (bit_pos),
    .cs_bit   (cs_bit),
    .fields_q (fields)
  );

  cs_flag_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock     (lock),
    .blk_done (blk_done),
    .fields   (fields),
    .flags_q  (flags)
  );

  assign flag_fs_44k   = flags.fs_44k;
  assign flag_fs_48k   = flags.fs_48k;
  assign flag_lock     = flags.locked;
  assign flag_pre_emph = flags.pre_emph;
  assign flag_non_pcm  = flags.non_pcm;

  if (STATUS_W > FLAG_W) begin : g_pad
    assign status_word = {{(STATUS_W - FLAG_W){1'b0}}, flags};
  end else begin : g_exact
    assign status_word = flags;
  end

endmodule

// File: tb/spdif_cs_flags_tb.sv
`timescale 1ns/1ps
module spdif_cs_flags_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sf_valid = 1'b0, sf_left = 1'b0, blk_start = 1'b0, cs_bit = 1'b0, lock = 1'b0;
  logic flag_fs_44k, flag_fs_48k, flag_lock, flag_pre_emph, flag_non_pcm;
  logic [7:0] status_word;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spdif_cs_flags u_dut (
    .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_left(sf_left),
    .blk_start(blk_start), .cs_bit(cs_bit), .lock(lock),
    .flag_fs_44k(flag_fs_44k), .flag_fs_48k(flag_fs_48k), .flag_lock(flag_lock),
    .flag_pre_emph(flag_pre_emph), .flag_non_pcm(flag_non_pcm),
    .status_word(status_word)
  );

  function automatic logic [7:0] exp_status(input logic [191:0] b);
    logic [7:0] s = 8'h00;
    s[0] = (b[27:24] == 4'b0000);
    s[1] = (b[27:24] == 4'b0010);
    s[2] = 1'b1;
    s[3] = (b[5:3] == 3'b001);
    s[4] = b[1];
    return s;
  endfunction

  function automatic logic [7:0] pins();
    return {3'b000, flag_non_pcm, flag_pre_emph, flag_lock, flag_fs_48k, flag_fs_44k};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", req, got, exp);
    end
  endtask

  task automatic send_frames(input logic [191:0] b, input int first, input int cnt,
                             input bit with_start);
    for (int i = first; i < first + cnt; i++) begin
      sf_valid = 1'b1; sf_left = 1'b1; cs_bit = b[i];
      blk_start = with_start && (i == first);
      @(posedge clk); #1;
      sf_valid = 1'b0; blk_start = 1'b0;
      @(posedge clk); #1;
      sf_valid = 1'b1; sf_left = 1'b0; cs_bit = 1'($urandom);
      blk_start = 1'($urandom);
      @(posedge clk); #1;
      sf_valid = 1'b0; blk_start = 1'b0;
    end
  endtask

  function automatic logic [191:0] rnd_block();
    logic [191:0] b;
    for (int k = 0; k < 6; k++) b[k*32 +: 32] = $urandom;
    case ($urandom % 4)
      0: b[27:24] = 4'b0000;
      1: b[27:24] = 4'b0010;
      2: b[27:24] = 4'b0011;
      default: ;
    endcase
    if ($urandom % 2 == 0) b[5:3] = 3'b001;
    return b;
  endfunction

  initial begin
    logic [191:0] blk, blk2, prev;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; lock = 1'b1;
    @(negedge clk);
    check("R1 reset status", status_word, 8'h00);
    check("R1 reset pins", pins(), 8'h00);

    // R7 R12: all-zero block, timing around bit 191 (R3)
    blk = '0;
    @(posedge clk); #1;
    send_frames(blk, 0, 191, 1'b1);
    sf_valid = 1'b1; sf_left = 1'b1; cs_bit = blk[191];
    @(negedge clk);
    check("R3 no update before last bit", status_word, 8'h00);
    @(posedge clk); #1 sf_valid = 1'b0;
    @(negedge clk);
    check("R7 R12 44k status after last bit", status_word, 8'b0000_0101);
    check("R12 pins match status", pins(), status_word);

    // R5 non-PCM
    blk = '0; blk[1] = 1'b1;
    send_frames(blk, 0, 192, 1'b1); @(negedge clk);
    check("R5 non-PCM", status_word, 8'b0001_0101);

    // R6 pre-emphasis and a near miss
    blk = '0; blk[3] = 1'b1;
    send_frames(blk, 0, 192, 1'b1); @(negedge clk);
    check("R6 pre-emph 001", status_word, 8'b0000_1101);
    blk = '0; blk[3] = 1'b1; blk[4] = 1'b1;
    send_frames(blk, 0, 192, 1'b1); @(negedge clk);
    check("R6 pre-emph 011 rejected", status_word, 8'b0000_0101);

    // R8 48k, 32k
    blk = '0; blk[25] = 1'b1;
    send_frames(blk, 0, 192, 1'b1); @(negedge clk);
    check("R8 48k", status_word, 8'b0000_0110);
    blk = '0; blk[24] = 1'b1; blk[25] = 1'b1;
    send_frames(blk, 0, 192, 1'b1); @(negedge clk);
    check("R8 32k neither rate", status_word, 8'b0000_0100);

    // R11 professional, copy and unrelated bits ignored
    blk = '1; blk[1] = 1'b0; blk[5:3] = 3'b001; blk[27:24] = 4'b0000;
    send_frames(blk, 0, 192, 1'b1); @(negedge clk);
    check("R11 other bits ignored", status_word, 8'b0000_1101);

    // R2: right subframes carry random bits and markers; result depends on left only
    blk = '0; blk[25] = 1'b1; blk[1] = 1'b1;
    send_frames(blk, 0, 192, 1'b1); @(negedge clk);
    check("R2 left-only capture", status_word, 8'b0001_0110);

    // R10: mid-block stability
    prev = blk;
    blk = '0;
    send_frames(blk, 0, 100, 1'b1); @(negedge clk);
    check("R10 hold mid-block", status_word, exp_status(prev));

    // R3: early marker restarts; interrupted block gives nothing
    blk2 = '0; blk2[3] = 1'b1;
    send_frames(blk2, 0, 150, 1'b1); @(negedge clk);
    check("R3 interrupted block no update", status_word, exp_status(prev));
    send_frames(blk2, 0, 192, 1'b1); @(negedge clk);
    check("R3 restarted block completes", status_word, exp_status(blk2));

    // R4: 192 frames without marker ignored
    blk = '0; blk[25] = 1'b1;
    send_frames(blk, 0, 192, 1'b0); @(negedge clk);
    check("R4 no marker ignored", status_word, exp_status(blk2));
    send_frames(blk, 0, 192, 1'b1); @(negedge clk);
    check("R4 marker resumes", status_word, exp_status(blk));

    // R9: lock loss clears next cycle
    @(posedge clk); #1 lock = 1'b0;
    @(negedge clk);
    check("R9 before edge", status_word, exp_status(blk));
    @(posedge clk); @(negedge clk);
    check("R9 cleared on lock loss", status_word, 8'h00);
    #1 lock = 1'b1;
    send_frames(blk, 0, 192, 1'b0); @(negedge clk);
    check("R9 relock no marker stays clear", status_word, 8'h00);
    send_frames(blk, 0, 100, 1'b1);
    lock = 1'b0; @(posedge clk); #1 lock = 1'b1;
    send_frames(blk, 100, 92, 1'b0); @(negedge clk);
    check("R9 block broken by lock loss", status_word, 8'h00);
    send_frames(blk, 0, 192, 1'b1); @(negedge clk);
    check("R9 lock flag after full block", status_word, exp_status(blk));

    // Random blocks
    for (int n = 0; n < 20; n++) begin
      blk = rnd_block();
      send_frames(blk, 0, 192, 1'b1); @(negedge clk);
      check("R5 R6 R7 R8 R11 random block", status_word, exp_status(blk));
      check("R12 random pins", pins(), exp_status(blk));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired got=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule